// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the bookkeeping half of a data cache: per line it stores an address tag with valid, dirty and recently-used flags, and it holds no data bytes. A client presents one byte address at a time with a read/write flag. The block decodes the address, compares the tag against every way of the selected set and, after a fixed delay, answers with hit or miss, the way that now holds the line, and whether a modified line has to be written back to the next level, together with that line's tag.

Lines are allocated on every miss, reads and writes alike. The policy is write-back, so a write sets the line's dirty flag and nothing is reported until the line is evicted. On a miss, an empty way in the set is used before any valid way is displaced. When the set is full, a separate replacement unit names the victim. That unit keeps one recently-used bit per line under the single-bit pseudo-LRU scheme. Every access, hit or fill, updates it for the touched way.

Both the request side and the response side are valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response has been taken, so only one access is in flight. The response rises a fixed number of cycles after acceptance and stays unchanged while `rsp_ready` is low. The default build is 64-bit addresses, 32-byte lines, 128 sets of 8 ways, and a 4-cycle response.

Top module: `cache_tag_dir`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0, every line is invalid and every recent bit is clear. The first access to any address therefore misses, fills way 0 and reports no write-back.
- R2: The address is split into offset (low log2(LINE_BYTES) bits), set index (next log2(SETS) bits) and tag (the remaining upper bits). Two addresses that differ only in the offset bits resolve to the same line.
- R3: An access whose set holds a valid line with a matching tag is reported with `rsp_hit`=1 and `rsp_way` equal to that way. It changes no tag.
- R4: On a miss in a set with at least one invalid way, the lowest-numbered invalid way is filled and reported in `rsp_way`.
- R5: On a miss in a full set, the victim is the lowest-numbered way whose recent bit is clear. Each access sets the touched way's recent bit. If that leaves every way of the set marked, all other ways of the set are cleared.
- R6: A write miss installs the line (write-allocate), and a later access to the same line hits.
- R7: A write sets the line's dirty bit and a read fill leaves it clear. A miss reports `rsp_wb_valid`=1, with `rsp_wb_tag` set to the victim's old tag, only when the victim was valid and dirty. A hit never reports a write-back.
- R8: `rsp_valid` rises exactly HIT_LAT clock edges after the edge that accepted the request.
- R9: `req_ready` is low from the accepting edge until the edge where the response is taken, and it is never high while `rsp_valid` is high. While `rsp_valid` is 1 and `rsp_ready` is 0, all response outputs hold steady.
- R10: A read hit on a dirty line leaves it dirty, so its later eviction still reports a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Client takes the response |
| rsp_hit | output | 1 | 1 = hit, 0 = miss (line allocated) |
| rsp_way | output | log2(WAYS) | Way that hit or was filled |
| rsp_wb_valid | output | 1 | Displaced line was dirty and must be written back |
| rsp_wb_tag | output | ADDR_W-log2(LINE_BYTES)-log2(SETS) | Tag of the displaced line |

## Verification
The bench builds the directory with 32-bit addresses, 8-byte lines, 4 sets of 4 ways and the 4-cycle response. With only four sets and a handful of tags, sets fill within a few requests. Victim selection, the clearing of recent bits and dirty write-backs then happen hundreds of times rather than never. Directed sequences walk one set through fill, recent-bit rollover and a dirty eviction. A long stretch of random reads and writes with a randomly stalling `rsp_ready` then exercises back-pressure on the response while a behavioural model is compared every cycle.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

  // Phases of the single-outstanding access sequencer.
  typedef enum logic [1:0] {
    CTD_IDLE = 2'd0,
    CTD_WAIT = 2'd1,
    CTD_RESP = 2'd2
  } ctd_phase_e;

endpackage

// File: rtl/ctd_addr_split.sv
module ctd_addr_split #(
  parameter  int ADDR_W = 64,
  parameter  int OFF_W  = 5,
  parameter  int IDX_W  = 7,
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  // Byte-within-line bits select no state in a tag-only directory.
  logic unused_off;
  assign unused_off = ^addr[OFF_W-1:0];

  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/ctd_set_match.sv
module ctd_set_match #(
  parameter  int WAYS  = 8,
  parameter  int TAG_W = 52,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [WAYS-1:0]            row_vld,
  input  logic [TAG_W-1:0]           look_tag,
  input  logic [WAY_W-1:0]           repl_way,
  output logic                       hit,
  output logic [WAY_W-1:0]           sel_way
);

  logic [WAYS-1:0]  way_hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] free_way;
  logic             has_free;

  // One comparator per way.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = row_vld[w] && (row_tag[w] == look_tag);
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    has_free = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (way_hit[i]) hit_way = WAY_W'(i);
      if (!row_vld[i]) begin
        free_way = WAY_W'(i);
        has_free = 1'b1;
      end
    end
  end

  assign hit     = |way_hit;
  assign sel_way = hit ? hit_way : (has_free ? free_way : repl_way);

endmodule

// File: rtl/ctd_plru.sv
module ctd_plru #(
  parameter  int SETS  = 128,
  parameter  int WAYS  = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAY_W-1:0] victim,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [WAY_W-1:0] upd_way
);

  logic [WAYS-1:0] rec_q [SETS];
  logic [WAYS-1:0] mark;
  logic [WAYS-1:0] touched;
  logic [WAYS-1:0] nxt_row;
  logic [WAYS-1:0] rd_row;

  assign mark    = WAYS'(1) << upd_way;
  assign touched = rec_q[upd_idx] | mark;
  assign nxt_row = (&touched) ? mark : touched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rec_q[s] <= '0;
    end else if (upd_en) begin
      rec_q[upd_idx] <= nxt_row;
    end
  end

  // Lowest way whose recent bit is clear.
  assign rd_row = rec_q[rd_idx];
  always_comb begin
    victim = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!rd_row[i]) victim = WAY_W'(i);
    end
  end

endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import ctd_pkg::*;
#(
  parameter  int ADDR_W     = 64,
  parameter  int LINE_BYTES = 32,
  parameter  int SETS       = 128,
  parameter  int WAYS       = 8,
  parameter  int HIT_LAT    = 4,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(SETS),
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W      = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_wb_valid,
  output logic [TAG_W-1:0]  rsp_wb_tag
);

  localparam int LAT_W = $clog2(HIT_LAT + 1);

  ctd_phase_e phase_q;
  logic [LAT_W-1:0] lat_q;
  logic accept;

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;

  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [WAYS-1:0]  vld_mem [SETS];
  logic [WAYS-1:0]  dty_mem [SETS];

  logic [WAYS-1:0][TAG_W-1:0] row_tag;
  logic [WAYS-1:0]            row_vld;
  logic [WAYS-1:0]            row_dty;

  logic [WAY_W-1:0] repl_way;
  logic [WAY_W-1:0] sel_way;
  logic             look_hit;
  logic             evict_dirty;

  assign req_ready = (phase_q == CTD_IDLE);
  assign accept    = req_valid && req_ready;

  ctd_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
    .addr (req_addr),
    .idx  (req_idx),
    .tag  (req_tag)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign row_tag[w] = tag_mem[req_idx][w];
  end
  assign row_vld = vld_mem[req_idx];
  assign row_dty = dty_mem[req_idx];

  ctd_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (req_idx),
    .victim  (repl_way),
    .upd_en  (accept),
    .upd_idx (req_idx),
    .upd_way (sel_way)
  );

  ctd_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .row_tag  (row_tag),
    .row_vld  (row_vld),
    .look_tag (req_tag),
    .repl_way (repl_way),
    .hit      (look_hit),
    .sel_way  (sel_way)
  );

  assign evict_dirty = !look_hit && row_vld[sel_way] && row_dty[sel_way];

  // Tag storage carries no reset; valid bits guard it.
  always_ff @(posedge clk) begin
    if (accept && !look_hit) tag_mem[req_idx][sel_way] <= req_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_mem[s] <= '0;
        dty_mem[s] <= '0;
      end
    end else if (accept) begin
      vld_mem[req_idx][sel_way] <= 1'b1;
      dty_mem[req_idx][sel_way] <= look_hit ? (row_dty[sel_way] | req_write) : req_write;
    end
  end

  // Response registers, captured once per access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit      <= 1'b0;
      rsp_way      <= '0;
      rsp_wb_valid <= 1'b0;
      rsp_wb_tag   <= '0;
    end else if (accept) begin
      rsp_hit      <= look_hit;
      rsp_way      <= sel_way;
      rsp_wb_valid <= evict_dirty;
      rsp_wb_tag   <= row_tag[sel_way];
    end
  end

  // Fixed-delay sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= CTD_IDLE;
      lat_q   <= '0;
    end else begin
      unique case (phase_q)
        CTD_IDLE: if (accept) begin
          phase_q <= CTD_WAIT;
          lat_q   <= LAT_W'(HIT_LAT - 1);
        end
        CTD_WAIT: begin
          if (lat_q == '0) phase_q <= CTD_RESP;
          else             lat_q   <= lat_q - 1'b1;
        end
        CTD_RESP: if (rsp_ready) phase_q <= CTD_IDLE;
        default: phase_q <= CTD_IDLE;
      endcase
    end
  end

  assign rsp_valid = (phase_q == CTD_RESP);

endmodule

// File: rtl/ctd_checker.sv
module ctd_checker #(
  parameter int WAY_W   = 3,
  parameter int TAG_W   = 52,
  parameter int HIT_LAT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [WAY_W-1:0] rsp_way,
  input logic             rsp_wb_valid,
  input logic [TAG_W-1:0] rsp_wb_tag
);

  localparam int CW = $clog2(HIT_LAT + 3);

  logic          pend_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (req_valid && req_ready) begin
      pend_q <= 1'b1;
      cnt_q  <= CW'(1);
    end else if (rsp_valid && rsp_ready) begin
      pend_q <= 1'b0;
    end else if (pend_q && !rsp_valid) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (pend_q && cnt_q == CW'(HIT_LAT + 1)));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_ready_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  assert_hold_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_way)
                                   && $stable(rsp_wb_valid) && $stable(rsp_wb_tag)));

  assert_no_wb_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !rsp_wb_valid);

  assert_free_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

endmodule

bind cache_tag_dir ctd_checker #(.WAY_W(WAY_W), .TAG_W(TAG_W), .HIT_LAT(HIT_LAT)) u_chk (.*);

// File: tb/sim_cache_tag_dir.sv
`timescale 1ns/1ps
module sim_cache_tag_dir;

  localparam int AW = 32;
  localparam int LB = 8;
  localparam int NS = 4;
  localparam int NW = 4;
  localparam int HL = 4;
  localparam int OW = 3;
  localparam int IW = 2;
  localparam int TW = AW - OW - IW;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_hit;
  logic [WW-1:0] rsp_way;
  logic rsp_wb_valid;
  logic [TW-1:0] rsp_wb_tag;

  always #10 clk = ~clk;

  cache_tag_dir #(.ADDR_W(AW), .LINE_BYTES(LB), .SETS(NS), .WAYS(NW), .HIT_LAT(HL)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [TW-1:0] m_tag [NS][NW];
  bit m_v [NS][NW];
  bit m_d [NS][NW];
  bit m_r [NS][NW];
  bit m_busy, m_resp, m_acc;
  int m_cnt;
  bit e_hit, e_wb;
  int e_way;
  logic [TW-1:0] e_wbtag;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[s, w]) begin m_v[s][w] = 0; m_d[s][w] = 0; m_r[s][w] = 0; end
      m_busy = 0; m_resp = 0; m_acc = 0; m_cnt = 0;
    end else begin
      bit pb, pr;
      pb = m_busy; pr = m_resp; m_acc = 0;
      if (pr && rsp_ready) m_resp = 0;
      if (pb) begin
        if (m_cnt == 0) begin m_busy = 0; m_resp = 1; end
        else m_cnt--;
      end
      if (!pb && !pr && req_valid) begin
        int s, w, all;
        logic [TW-1:0] t;
        s = int'(req_addr[OW +: IW]);
        t = req_addr[AW-1 -: TW];
        w = -1;
        for (int i = 0; i < NW; i++) if (w < 0 && m_v[s][i] && m_tag[s][i] == t) w = i;
        e_hit = (w >= 0);
        e_wb = 0;
        if (!e_hit) begin
          for (int i = 0; i < NW; i++) if (w < 0 && !m_v[s][i]) w = i;
          for (int i = 0; i < NW; i++) if (w < 0 && !m_r[s][i]) w = i;
          e_wb = m_v[s][w] && m_d[s][w];
          e_wbtag = m_tag[s][w];
          m_tag[s][w] = t;
          m_v[s][w] = 1;
          m_d[s][w] = req_write;
        end else begin
          m_d[s][w] = m_d[s][w] | req_write;
        end
        e_way = w;
        m_r[s][w] = 1;
        all = 1;
        for (int i = 0; i < NW; i++) if (!m_r[s][i]) all = 0;
        if (all) for (int i = 0; i < NW; i++) if (i != w) m_r[s][i] = 0;
        m_busy = 1; m_cnt = HL - 1; m_acc = 1;
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == !(m_busy || m_resp), "R9", "req_ready", req_ready, !(m_busy || m_resp));
      chk(rsp_valid == m_resp, "R8", "rsp_valid", rsp_valid, m_resp);
      if (m_resp && rsp_valid) begin
        chk(rsp_hit == e_hit, "R3", "rsp_hit", rsp_hit, e_hit);
        chk(int'(rsp_way) == e_way, "R4/R5", "rsp_way", rsp_way, e_way);
        chk(rsp_wb_valid == e_wb, "R7", "rsp_wb_valid", rsp_wb_valid, e_wb);
        if (e_wb) chk(rsp_wb_tag == e_wbtag, "R7", "rsp_wb_tag", rsp_wb_tag, e_wbtag);
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [AW-1:0] mk(input int t, input int s, input int o);
    return (AW'(t) << (OW + IW)) | (AW'(s) << OW) | AW'(o);
  endfunction

  bit g_hit, g_wb;
  int g_way, g_lat;
  logic [TW-1:0] g_tag;

  task automatic access(input logic [AW-1:0] a, input bit wr);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr; rsp_ready = 1;
    @(posedge clk);
    g_lat = 0;
    forever begin
      @(negedge clk);
      req_valid = 0;
      if (rsp_valid) break;
      g_lat++;
    end
    g_hit = rsp_hit; g_way = int'(rsp_way); g_wb = rsp_wb_valid; g_tag = rsp_wb_tag;
  endtask

  task automatic expect_rsp(input string req, input bit h, input int w, input bit wb,
                            input int wt);
    chk(g_hit == h, req, "hit", g_hit, h);
    chk(g_way == w, req, "way", g_way, w);
    chk(g_wb == wb, req, "writeback", g_wb, wb);
    if (wb) chk(g_tag == TW'(wt), req, "wb tag", g_tag, wt);
    chk(g_lat == HL, "R8", "latency", g_lat, HL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1;

    // Set 0: fill, recent rollover, clean then dirty eviction.
    access(mk(1, 0, 0), 0); expect_rsp("R1", 0, 0, 0, 0);
    access(mk(1, 0, 5), 0); expect_rsp("R2", 1, 0, 0, 0);
    access(mk(2, 0, 1), 1); expect_rsp("R6", 0, 1, 0, 0);
    access(mk(2, 0, 7), 0); expect_rsp("R6", 1, 1, 0, 0);
    access(mk(3, 0, 0), 0); expect_rsp("R4", 0, 2, 0, 0);
    access(mk(4, 0, 0), 0); expect_rsp("R4", 0, 3, 0, 0);
    access(mk(5, 0, 0), 0); expect_rsp("R5", 0, 0, 0, 0);
    access(mk(6, 0, 0), 0); expect_rsp("R7", 0, 1, 1, 2);
    access(mk(3, 0, 2), 0); expect_rsp("R3", 1, 2, 0, 0);

    // Set 1: dirty line survives a read hit.
    access(mk(7, 1, 0), 1); expect_rsp("R6", 0, 0, 0, 0);
    access(mk(7, 1, 3), 0); expect_rsp("R10", 1, 0, 0, 0);
    access(mk(8, 1, 0), 0); expect_rsp("R4", 0, 1, 0, 0);
    access(mk(9, 1, 0), 0); expect_rsp("R4", 0, 2, 0, 0);
    access(mk(10, 1, 0), 0); expect_rsp("R4", 0, 3, 0, 0);
    access(mk(11, 1, 0), 0); expect_rsp("R10", 0, 0, 1, 7);

    // Random traffic with response back-pressure (R5, R7, R9 via model).
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      if (!req_valid || m_acc) begin
        req_valid = ($urandom % 4) != 0;
        req_addr  = mk(int'($urandom % 6), int'($urandom % NS), int'($urandom % LB));
        req_write = $urandom % 2;
      end
      rsp_ready = ($urandom % 3) != 0;
    end
    @(negedge clk);
    req_valid = 0; rsp_ready = 1;
    repeat (HL + 3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule